// File: doc/BRIEF.md
# Multi-Source Entropy Conditioning Unit

This block is the digital back end of a hardware random number generator. Three raw noise bit streams come in, one per analog cell. Each stream has its own enable. The enabled bits are XOR-merged into a single bit, and that bit enters a 64-bit conditioning register on every clock. The register runs in one of two modes: a CRC-style Galois LFSR, or a plain shift register with no feedback.

Software reads the conditioning register as a 64-bit word through a valid/ready handshake. In LFSR mode a read interlock holds ready low for a programmed number of cycles after each accepted read, so that fresh noise can build up before the next word is taken. Around 2048 cycles is the usual setting.

A 25-bit control word holds the source enables, the mode bit and the interlock wait. It also holds three analog tuning fields (mux select, oscillator rate code, voltage bypass). The block stores those analog fields and drives them out without interpreting them.

Top module: `entropy_cond_unit`

## Requirements
- R1: After reset the data word is zero, the control word is zero, and rd_ready_o is 1, so the first read is not stalled.
- R2: Source k (k = 0, 1, 2) takes part only when control bit k is 1. A disabled source has no effect on the data word.
- R3: The gated source bits are XORed into one merged bit, and that bit enters the conditioning register on every clock cycle.
- R4: When control bit 3 is 1 the register works as a Galois LFSR. It shifts left by one, and whenever the outgoing bit 63 XOR the merged bit is 1, the constant 0x231DCEE91262B8A3 is XORed into the shifted value.
- R5: When control bit 3 is 0 the register shifts left by one and takes the merged bit into bit 0, with no feedback.
- R6: With control bit 3 set and wait field W (control bits 24:9), a read accepted in cycle t holds rd_ready_o low for exactly W cycles. It is high again in cycle t+W+1. With W = 0 it never drops.
- R7: With control bit 3 clear, rd_ready_o stays 1 whatever the wait field holds and however often reads arrive.
- R8: mux_sel_o always equals control bits 5:4, vco_rate_o equals bits 7:6, and vco_bypass_o equals bit 8.
- R9: A write with ctl_we_i high is visible on ctl_rdata_o from the next cycle, and the new settings govern the register update from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| noise_i | input | 3 | Raw noise bits, one per source |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 25 | Control word write data |
| ctl_rdata_o | output | 25 | Current control word |
| rd_valid_i | input | 1 | Data read request |
| rd_ready_o | output | 1 | Interlock open; a read is accepted when valid and ready are both high |
| rd_data_o | output | 64 | Conditioning register contents |
| mux_sel_o | output | 2 | Stored analog mux select |
| vco_rate_o | output | 2 | Stored oscillator rate code |
| vco_bypass_o | output | 1 | Stored oscillator voltage bypass |

## Verification
The hardest case to reach from the ports is an exact LFSR value. Under live noise the register value depends on the whole input history, so a bug in the polynomial could hide behind a model that makes the same mistake. The stimulus therefore first flushes the register to zero in shift mode with the merged bit held at 0. It then switches to LFSR mode and injects a single 1. The next word must then equal the polynomial constant itself, and the word after that must be the constant shifted left by one. The interlock is run at waits of 0, 5 and the usual 2048, and the stall length is counted cycle by cycle.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  localparam int N_SRC  = 3;
  localparam int WAIT_W = 16;
  localparam int CTL_W  = WAIT_W + 1 + 2 + 2 + 1 + N_SRC;
  localparam logic [63:0] CRC_POLY = 64'h231D_CEE9_1262_B8A3;
  localparam int NORMAL_WAIT = 2048;

  typedef struct packed {
    logic [WAIT_W-1:0] wait_cyc;   // 24:9
    logic              vco_bypass; // 8
    logic [1:0]        vco_rate;   // 7:6
    logic [1:0]        mux_sel;    // 5:4
    logic              lfsr_mode;  // 3
    logic [N_SRC-1:0]  src_en;     // 2:0
  } ctl_t;
endpackage

// File: rtl/ecu_ctl_reg.sv
module ecu_ctl_reg
  import ecu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output ctl_t             ctl_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (we_i) ctl_q <= ctl_t'(wdata_i);
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/ecu_conditioner.sv
module ecu_conditioner #(
  parameter int                DATA_W = 64,
  parameter int                N_SRC  = 3,
  parameter logic [DATA_W-1:0] POLY   = DATA_W'(ecu_pkg::CRC_POLY)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  noise_i,
  input  logic [N_SRC-1:0]  src_en_i,
  input  logic              lfsr_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int MSB = DATA_W - 1;

  logic [N_SRC-1:0]  gated;
  logic              merged;
  logic              fb;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] nxt;
  logic [DATA_W-1:0] q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_gate
    assign gated[g] = noise_i[g] & src_en_i[g];
  end

  assign merged  = ^gated;
  assign fb      = q[MSB] ^ merged;
  assign shifted = {q[MSB-1:0], 1'b0};

  always_comb begin
    if (lfsr_i) nxt = fb ? (shifted ^ POLY) : shifted;
    else        nxt = {q[MSB-1:0], merged};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign data_o = q;
endmodule

// File: rtl/ecu_interlock.sv
module ecu_interlock #(
  parameter int WAIT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lfsr_i,
  input  logic [WAIT_W-1:0] wait_i,
  input  logic              valid_i,
  output logic              ready_o
);
  logic [WAIT_W-1:0] cnt_q;
  logic              idle;
  logic              accept;

  assign idle    = (cnt_q == '0);
  assign ready_o = !lfsr_i || idle;
  assign accept  = valid_i && ready_o;

  // reload only when the interlock is active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (accept && lfsr_i)  cnt_q <= wait_i;
    else if (!idle)             cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/entropy_cond_unit.sv
module entropy_cond_unit
  import ecu_pkg::*;
#(
  parameter int                DATA_W = 64,
  parameter logic [DATA_W-1:0] POLY   = DATA_W'(CRC_POLY)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  noise_i,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  output logic [CTL_W-1:0]  ctl_rdata_o,
  input  logic              rd_valid_i,
  output logic              rd_ready_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [1:0]        mux_sel_o,
  output logic [1:0]        vco_rate_o,
  output logic              vco_bypass_o
);
  ctl_t ctl;

  ecu_ctl_reg u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_we_i),
    .wdata_i (ctl_wdata_i),
    .ctl_o   (ctl)
  );

  ecu_conditioner #(.DATA_W(DATA_W), .N_SRC(N_SRC), .POLY(POLY)) u_cond (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .noise_i  (noise_i),
    .src_en_i (ctl.src_en),
    .lfsr_i   (ctl.lfsr_mode),
    .data_o   (rd_data_o)
  );

  ecu_interlock #(.WAIT_W(WAIT_W)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lfsr_i  (ctl.lfsr_mode),
    .wait_i  (ctl.wait_cyc),
    .valid_i (rd_valid_i),
    .ready_o (rd_ready_o)
  );

  assign ctl_rdata_o  = ctl;
  assign mux_sel_o    = ctl.mux_sel;
  assign vco_rate_o   = ctl.vco_rate;
  assign vco_bypass_o = ctl.vco_bypass;
endmodule

// File: rtl/ecu_checker.sv
module ecu_checker #(
  parameter int                DATA_W = 64,
  parameter logic [DATA_W-1:0] POLY   = DATA_W'(ecu_pkg::CRC_POLY)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        noise_i,
  input logic              ctl_we_i,
  input logic [24:0]       ctl_wdata_i,
  input logic [24:0]       ctl_rdata_o,
  input logic              rd_valid_i,
  input logic              rd_ready_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [1:0]        mux_sel_o,
  input logic [1:0]        vco_rate_o,
  input logic              vco_bypass_o
);
  logic merged;
  assign merged = ^(noise_i & ctl_rdata_o[2:0]);

  // R4
  lfsr_nofb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rdata_o[3] && !(rd_data_o[DATA_W-1] ^ merged))
      |=> rd_data_o == {$past(rd_data_o[DATA_W-2:0]), 1'b0});

  // R4
  lfsr_fb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rdata_o[3] && (rd_data_o[DATA_W-1] ^ merged))
      |=> rd_data_o == ({$past(rd_data_o[DATA_W-2:0]), 1'b0} ^ POLY));

  // R5
  plain_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_rdata_o[3] |=> rd_data_o == {$past(rd_data_o[DATA_W-2:0]), $past(merged)});

  // R6
  stall_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_ready_o && ctl_rdata_o[3] && ctl_rdata_o[24:9] != 16'd0 && !ctl_we_i)
      |=> !rd_ready_o);

  // R6
  stall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_ready_o) |-> ($past(rd_valid_i) || $past(ctl_we_i)));

  // R7
  plain_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_rdata_o[3] |-> rd_ready_o);

  // R8
  analog_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {vco_bypass_o, vco_rate_o, mux_sel_o} == ctl_rdata_o[8:4]);

  // R9
  ctl_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> ctl_rdata_o == $past(ctl_wdata_i));
endmodule

bind entropy_cond_unit ecu_checker #(.DATA_W(DATA_W), .POLY(POLY)) u_chk (.*);

// File: tb/entropy_cond_unit_bench.sv
`timescale 1ns/1ps
module entropy_cond_unit_bench;
  localparam logic [63:0] POLY = 64'h231D_CEE9_1262_B8A3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  noise = '0;
  logic        ctl_we = 1'b0;
  logic [24:0] ctl_wdata = '0;
  logic [24:0] ctl_rdata;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [63:0] rd_data;
  logic [1:0]  mux_sel, vco_rate;
  logic        vco_bypass;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  entropy_cond_unit u_entropy_cond_unit (
    .clk_i(clk), .rst_ni(rst_n), .noise_i(noise),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
    .rd_valid_i(rd_valid), .rd_ready_o(rd_ready), .rd_data_o(rd_data),
    .mux_sel_o(mux_sel), .vco_rate_o(vco_rate), .vco_bypass_o(vco_bypass)
  );

  // reference model of the conditioning register, from R2..R5 and R9
  function automatic logic [63:0] mdl(logic [63:0] r, logic [24:0] c, logic [2:0] n);
    logic b;
    b = ^(n & c[2:0]);
    if (c[3]) return {r[62:0], 1'b0} ^ (((r[63] ^ b) != 1'b0) ? POLY : 64'd0);
    return {r[62:0], b};
  endfunction

  logic [63:0] exp_reg;
  logic [24:0] exp_ctl;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_reg <= '0;
      exp_ctl <= '0;
    end else begin
      if (ctl_we) exp_ctl <= ctl_wdata;
      exp_reg <= mdl(exp_reg, exp_ctl, noise);
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [24:0] v);
    ctl_wdata = v;
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 data", rd_data, 64'd0);
    chk("R1 ctl", 64'(ctl_rdata), 64'd0);
    chk("R1 ready", 64'(rd_ready), 64'd1);
  endtask

  task automatic t_plain;
    wr_ctl(25'h7);
    chk("R9 readback", 64'(ctl_rdata), 64'h7);
    for (int i = 0; i < 80; i++) begin
      noise = 3'((i * 5) ^ (i >> 2));
      @(negedge clk);
      chk("R5 shift", rd_data, exp_reg);
    end
  endtask

  task automatic t_gate;
    wr_ctl(25'h2);
    noise = 3'b101;
    repeat (64) @(negedge clk);
    chk("R2 disabled sources", rd_data, 64'd0);
    noise = 3'b010;
    repeat (64) @(negedge clk);
    chk("R2 enabled source", rd_data, '1);
  endtask

  task automatic t_merge;
    wr_ctl(25'h7);
    noise = 3'b111;
    repeat (64) @(negedge clk);
    chk("R3 xor of three ones", rd_data, '1);
    noise = 3'b011;
    repeat (64) @(negedge clk);
    chk("R3 xor of two ones", rd_data, 64'd0);
  endtask

  task automatic t_lfsr;
    noise = 3'b000;
    wr_ctl(25'h9);
    chk("R4 zero hold", rd_data, 64'd0);
    noise = 3'b001;
    @(negedge clk);
    chk("R4 single inject", rd_data, POLY);
    noise = 3'b000;
    @(negedge clk);
    chk("R4 plain step", rd_data, POLY << 1);
    wr_ctl(25'hF);
    for (int i = 0; i < 100; i++) begin
      noise = 3'((i * 3) ^ (i >> 1));
      @(negedge clk);
      chk("R4 lfsr run", rd_data, exp_reg);
    end
  endtask

  task automatic t_lock(int w);
    int lows = 0;
    wr_ctl((25'(w) << 9) | 25'h8);
    for (int i = 0; i < 4000 && !rd_ready; i++) @(negedge clk);
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    for (int i = 0; i < w + 10 && !rd_ready; i++) begin
      lows++;
      @(negedge clk);
    end
    chk($sformatf("R6 stall length w=%0d", w), 64'(lows), 64'(w));
  endtask

  task automatic t_plain_nostall;
    wr_ctl((25'd5 << 9) | 25'h7);
    rd_valid = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R7 ready in plain mode", 64'(rd_ready), 64'd1);
    end
    rd_valid = 1'b0;
  endtask

  task automatic t_fields;
    wr_ctl(25'h190);
    chk("R9 readback", 64'(ctl_rdata), 64'h190);
    chk("R8 mux_sel", 64'(mux_sel), 64'd1);
    chk("R8 vco_rate", 64'(vco_rate), 64'd2);
    chk("R8 vco_bypass", 64'(vco_bypass), 64'd1);
    wr_ctl(25'h060);
    chk("R8 fields", 64'({vco_bypass, vco_rate, mux_sel}), 64'h06);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_gate();
    t_merge();
    t_lfsr();
    t_lock(5);
    t_lock(0);
    t_lock(2048);
    t_plain_nostall();
    t_fields();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule